// File: doc/BRIEF.md
# Bit-17 Page Half-Swap Engine

This engine repairs the contents of a 4 KiB page after the page has moved to a physical location whose address bit 17 differs from the one it had when its contents were last recorded. Each page has two stored bits. One says whether a bit-17 value was ever recorded for the page. The other holds that recorded value. A save command fills both bits from a physical address.

A start command carries a page index and the page's new physical address. One cycle after the start is accepted, the engine compares bit 17 of the new address with the recorded value. It walks the page only if a value was recorded and the two bits differ. During the walk it uses a 64-bit read/write memory port. In every 128-byte chunk, it exchanges the lower 64 bytes with the upper 64 bytes, and it parks one half in a small local buffer while it does so. A one-cycle completion pulse ends every accepted command. That pulse reports whether the page was rewritten, and the caller can use it to mark the page as modified.

Top module: `pg_half_swap`

## Requirements
- R1: After reset `busy_o`, `done_o`, `done_dirty_o` and `mem_req_o` are low. A start seen while `busy_o` is low is accepted, and `busy_o` is high from the next cycle until the cycle of the last memory write. Without a swap, `busy_o` is high for only one cycle.
- R2: An accepted start swaps the page only when the page has a recorded value and bit 17 of `start_phys_i` differs from it. Both polarities of the mismatch swap. Equal values do not swap.
- R3: A start on a page with no recorded value performs no memory access and finishes as a no-swap job.
- R4: A swap exchanges beat `{p, c, 0, b}` with beat `{p, c, 1, b}` for every chunk c (0..31) and beat b (0..7) of page p. The beat address is laid out as `{page, chunk[4:0], half, beat[2:0]}` over 64-bit words.
- R5: A save stores bit 17 of `save_phys_i` for `save_page_i` and marks the page as recorded. Saves are taken while busy as well. A swap never changes the recorded values, so a repeated start with the same address swaps again.
- R6: `done_o` is a one-cycle pulse in the cycle after the job's last busy cycle. `done_dirty_o` is high only together with `done_o`, and only when the page was swapped.
- R7: A start that arrives while `busy_o` is high is ignored and leaves memory untouched.
- R8: The memory port is requested only while busy, and only within the active page. Read data is taken one cycle after the read request.
- R9: A swap job is busy for exactly 1 + 32 × 32 = 1025 cycles: 8 reads of the lower half, then read-upper, write-lower and write-upper for each of the 8 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_valid_i | input | 1 | Start command strobe |
| start_page_i | input | PG_W | Page index of the start command |
| start_phys_i | input | PHYS_W | New physical address of the page |
| save_valid_i | input | 1 | Save command strobe |
| save_page_i | input | PG_W | Page index to record |
| save_phys_i | input | PHYS_W | Physical address whose bit 17 is recorded |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | MADDR_W | Beat address {page, chunk, half, beat} |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after a read |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_dirty_o | output | 1 | Page was rewritten (valid with done_o) |

## Verification
The main function is tried on four kinds of page state:
- a page with no recorded value, which separates "absent" from "equal";
- equal recorded and new bits, which must leave memory as it was;
- each polarity of mismatch, which shows the comparison is an inequality and not a test of one polarity;
- two swaps in a row on the same page, which must restore the original data and so shows that a swap leaves the recorded value alone.

Memory is seeded with values that are unique per word, so any wrong pairing of beats or halves shows up in the full-memory comparison after every job. A start sent in the middle of a swap, a save to another page during a swap, and a start in the completion cycle itself separate the acceptance rules from the flag-store update.

// File: rtl/pg_half_swap_pkg.sv
package pg_half_swap_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE   = 3'd0,
        WALK_DECIDE = 3'd1,
        WALK_RD_LO  = 3'd2,
        WALK_RD_HI  = 3'd3,
        WALK_WR_LO  = 3'd4,
        WALK_WR_HI  = 3'd5
    } walk_state_e;

endpackage

// File: rtl/pg_flag_store.sv
module pg_flag_store #(
    parameter int NUM_PAGES = 4,
    parameter int PG_W      = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            save_en_i,
    input  logic [PG_W-1:0] save_page_i,
    input  logic            save_bit_i,
    input  logic [PG_W-1:0] rd_page_i,
    output logic            rd_vld_o,
    output logic            rd_bit_o
);

    typedef struct packed {
        logic [NUM_PAGES-1:0] vld;
        logic [NUM_PAGES-1:0] bits;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (save_en_i) begin
            fl_d.vld[save_page_i]  = 1'b1;
            fl_d.bits[save_page_i] = save_bit_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end

    assign rd_vld_o = fl_q.vld[rd_page_i];
    assign rd_bit_o = fl_q.bits[rd_page_i];

endmodule

// File: rtl/pg_half_buf.sv
module pg_half_buf #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] slot_rd [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [DATA_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (we_i && (widx_i == IDX_W'(gi))) slot_d = wdata_i;
        end

        always_ff @(posedge clk_i) begin
            slot_q <= slot_d;
        end

        assign slot_rd[gi] = slot_q;
    end

    assign rdata_o = slot_rd[ridx_i];

endmodule

// File: rtl/pg_walk_ctrl.sv
module pg_walk_ctrl
    import pg_half_swap_pkg::*;
#(
    parameter int PG_W       = 2,
    parameter int CH_W       = 5,
    parameter int HB_W       = 3,
    parameter int NUM_CHUNKS = 32,
    parameter int HALF_BEATS = 8,
    localparam int MADDR_W   = PG_W + CH_W + 1 + HB_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_valid_i,
    input  logic [PG_W-1:0]    start_page_i,
    input  logic               start_bit_i,
    input  logic               flag_vld_i,
    input  logic               flag_bit_i,
    output logic [PG_W-1:0]    flag_page_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic               wsel_buf_o,
    output logic               cap_we_o,
    output logic [HB_W-1:0]    cap_idx_o,
    output logic [HB_W-1:0]    rd_idx_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               done_dirty_o
);

    localparam logic [HB_W-1:0] BEAT_LAST  = HB_W'(HALF_BEATS - 1);
    localparam logic [CH_W-1:0] CHUNK_LAST = CH_W'(NUM_CHUNKS - 1);

    typedef struct packed {
        walk_state_e     state;
        logic [PG_W-1:0] page;
        logic            nbit;
        logic [CH_W-1:0] chunk;
        logic [HB_W-1:0] beat;
        logic            cap_v;
        logic [HB_W-1:0] cap_idx;
        logic            done;
        logic            dirty;
    } walk_t;

    walk_t st_d, st_q;
    logic  hi_half;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.dirty = 1'b0;
        st_d.cap_v = 1'b0;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        wsel_buf_o = 1'b0;
        hi_half    = 1'b0;
        case (st_q.state)
            WALK_IDLE: begin
                if (start_valid_i) begin
                    st_d.state = WALK_DECIDE;
                    st_d.page  = start_page_i;
                    st_d.nbit  = start_bit_i;
                end
            end
            WALK_DECIDE: begin
                if (flag_vld_i && (flag_bit_i != st_q.nbit)) begin
                    st_d.state = WALK_RD_LO;
                    st_d.chunk = '0;
                    st_d.beat  = '0;
                end else begin
                    st_d.state = WALK_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            WALK_RD_LO: begin
                mem_req_o    = 1'b1;
                st_d.cap_v   = 1'b1;
                st_d.cap_idx = st_q.beat;
                if (st_q.beat == BEAT_LAST) begin
                    st_d.beat  = '0;
                    st_d.state = WALK_RD_HI;
                end else begin
                    st_d.beat = st_q.beat + 1'b1;
                end
            end
            WALK_RD_HI: begin
                mem_req_o  = 1'b1;
                hi_half    = 1'b1;
                st_d.state = WALK_WR_LO;
            end
            WALK_WR_LO: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                st_d.state = WALK_WR_HI;
            end
            WALK_WR_HI: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                hi_half    = 1'b1;
                wsel_buf_o = 1'b1;
                if (st_q.beat == BEAT_LAST) begin
                    st_d.beat = '0;
                    if (st_q.chunk == CHUNK_LAST) begin
                        st_d.state = WALK_IDLE;
                        st_d.done  = 1'b1;
                        st_d.dirty = 1'b1;
                    end else begin
                        st_d.chunk = st_q.chunk + 1'b1;
                        st_d.state = WALK_RD_LO;
                    end
                end else begin
                    st_d.beat  = st_q.beat + 1'b1;
                    st_d.state = WALK_RD_HI;
                end
            end
            default: st_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_page_o  = st_q.page;
    assign mem_addr_o   = {st_q.page, st_q.chunk, hi_half, st_q.beat};
    assign cap_we_o     = st_q.cap_v;
    assign cap_idx_o    = st_q.cap_idx;
    assign rd_idx_o     = st_q.beat;
    assign busy_o       = (st_q.state != WALK_IDLE);
    assign done_o       = st_q.done;
    assign done_dirty_o = st_q.dirty;

endmodule

// File: rtl/pg_half_swap.sv
module pg_half_swap #(
    parameter int PAGE_BYTES  = 4096,
    parameter int CHUNK_BYTES = 128,
    parameter int DATA_W      = 64,
    parameter int NUM_PAGES   = 4,
    parameter int PHYS_W      = 40,
    parameter int SWAP_BIT    = 17,
    localparam int BEAT_BYTES = DATA_W / 8,
    localparam int HALF_BEATS = CHUNK_BYTES / 2 / BEAT_BYTES,
    localparam int NUM_CHUNKS = PAGE_BYTES / CHUNK_BYTES,
    localparam int PG_W       = $clog2(NUM_PAGES),
    localparam int CH_W       = $clog2(NUM_CHUNKS),
    localparam int HB_W       = $clog2(HALF_BEATS),
    localparam int MADDR_W    = PG_W + CH_W + 1 + HB_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_valid_i,
    input  logic [PG_W-1:0]    start_page_i,
    input  logic [PHYS_W-1:0]  start_phys_i,
    input  logic               save_valid_i,
    input  logic [PG_W-1:0]    save_page_i,
    input  logic [PHYS_W-1:0]  save_phys_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               done_dirty_o
);

    logic            unused_phys;
    logic [PG_W-1:0] flag_page;
    logic            flag_vld, flag_bit;
    logic            wsel_buf, cap_we;
    logic [HB_W-1:0] cap_idx, rd_idx;
    logic [DATA_W-1:0] buf_rdata;

    assign unused_phys = ^{start_phys_i, save_phys_i};

    pg_flag_store #(
        .NUM_PAGES (NUM_PAGES),
        .PG_W      (PG_W)
    ) flags_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .save_en_i   (save_valid_i),
        .save_page_i (save_page_i),
        .save_bit_i  (save_phys_i[SWAP_BIT]),
        .rd_page_i   (flag_page),
        .rd_vld_o    (flag_vld),
        .rd_bit_o    (flag_bit)
    );

    pg_half_buf #(
        .DEPTH  (HALF_BEATS),
        .IDX_W  (HB_W),
        .DATA_W (DATA_W)
    ) hbuf_i (
        .clk_i   (clk_i),
        .we_i    (cap_we),
        .widx_i  (cap_idx),
        .wdata_i (mem_rdata_i),
        .ridx_i  (rd_idx),
        .rdata_o (buf_rdata)
    );

    pg_walk_ctrl #(
        .PG_W       (PG_W),
        .CH_W       (CH_W),
        .HB_W       (HB_W),
        .NUM_CHUNKS (NUM_CHUNKS),
        .HALF_BEATS (HALF_BEATS)
    ) ctrl_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_valid_i (start_valid_i),
        .start_page_i  (start_page_i),
        .start_bit_i   (start_phys_i[SWAP_BIT]),
        .flag_vld_i    (flag_vld),
        .flag_bit_i    (flag_bit),
        .flag_page_o   (flag_page),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .wsel_buf_o    (wsel_buf),
        .cap_we_o      (cap_we),
        .cap_idx_o     (cap_idx),
        .rd_idx_o      (rd_idx),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .done_dirty_o  (done_dirty_o)
    );

    assign mem_wdata_o = wsel_buf ? buf_rdata : mem_rdata_i;

endmodule

// File: rtl/pg_half_swap_chk.sv
module pg_half_swap_chk #(
    parameter int PG_W    = 2,
    parameter int MADDR_W = 11
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               start_valid_i,
    input logic [PG_W-1:0]    start_page_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               done_dirty_o,
    input logic               mem_req_o,
    input logic [MADDR_W-1:0] mem_addr_o
);

    logic [PG_W-1:0] job_page_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       job_page_q <= '0;
        else if (start_valid_i && !busy_o) job_page_q <= start_page_i;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_valid_i && !busy_o |=> busy_o); // R1
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> busy_o); // R8
    AST_REQ_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> (mem_addr_o[MADDR_W-1 -: PG_W] == job_page_q)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o))); // R6
    AST_DIRTY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_dirty_o |-> done_o); // R6

endmodule

bind pg_half_swap pg_half_swap_chk #(
    .PG_W    (PG_W),
    .MADDR_W (MADDR_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_valid_i (start_valid_i),
    .start_page_i  (start_page_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .done_dirty_o  (done_dirty_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o)
);

// File: tb/pg_half_swap_tb_top.sv
module pg_half_swap_tb_top;

    localparam int NPG   = 4;
    localparam int WORDS = NPG * 512;
    localparam int SWAP_CYC = 1025;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [1:0]  start_page = '0;
    logic [39:0] start_phys = '0;
    logic        save_valid = 1'b0;
    logic [1:0]  save_page = '0;
    logic [39:0] save_phys = '0;
    logic        mem_req, mem_we;
    logic [10:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        busy, done, done_dirty;

    logic [63:0] mem    [WORDS];
    logic [63:0] shadow [WORDS];
    logic [63:0] orig   [WORDS];

    int n_chk = 0;
    int n_err = 0;

    int       m_cnt = 0;
    bit       m_done = 0, m_dirty = 0, m_swap = 0;
    int       m_page = 0;
    bit [3:0] m_vld = '0, m_flag = '0;

    always #2 clk = ~clk;

    pg_half_swap dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_valid_i (start_valid),
        .start_page_i  (start_page),
        .start_phys_i  (start_phys),
        .save_valid_i  (save_valid),
        .save_page_i   (save_page),
        .save_phys_i   (save_phys),
        .mem_req_o     (mem_req),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .mem_rdata_i   (mem_rdata),
        .busy_o        (busy),
        .done_o        (done),
        .done_dirty_o  (done_dirty)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mem_vs_shadow();
        int bad = 0;
        for (int i = 0; i < WORDS; i++) if (mem[i] !== shadow[i]) bad++;
        return bad;
    endfunction

    function automatic int page_vs_orig(input int p);
        int bad = 0;
        for (int i = p * 512; i < p * 512 + 512; i++) if (mem[i] !== orig[i]) bad++;
        return bad;
    endfunction

    // memory: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    // behavioural reference model
    always @(posedge clk) begin
        int old;
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_dirty = 0; m_vld = '0; m_flag = '0;
        end else begin
            old     = m_cnt;
            m_done  = (old == 1);
            m_dirty = (old == 1) && m_swap;
            if (save_valid) begin
                m_vld[save_page]  = 1'b1;
                m_flag[save_page] = save_phys[17];
            end
            if (old > 0) m_cnt = old - 1;
            else if (start_valid) begin
                m_page = int'(start_page);
                m_swap = m_vld[start_page] && (m_flag[start_page] != start_phys[17]);
                m_cnt  = m_swap ? SWAP_CYC : 1;
                if (m_swap) begin
                    for (int c = 0; c < 32; c++) begin
                        for (int b = 0; b < 8; b++) begin
                            int lo;
                            logic [63:0] t;
                            lo = m_page * 512 + c * 16 + b;
                            t = shadow[lo];
                            shadow[lo] = shadow[lo + 8];
                            shadow[lo + 8] = t;
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === (m_cnt > 0), "R1 busy", busy, m_cnt > 0);
            chk(done === m_done, "R6 done", done, m_done);
            chk(done_dirty === m_dirty, "R6 dirty", done_dirty, m_dirty);
            if (mem_req)
                chk((m_cnt > 0) && m_swap && (int'(mem_addr[10:9]) == m_page),
                    "R8 port scope", mem_addr, m_page);
            if (done)
                chk(mem_vs_shadow() == 0, "R4 memory image", mem_vs_shadow(), 0);
        end
    end

    task automatic do_start(input int p, input bit b17);
        start_valid = 1'b1;
        start_page  = 2'(p);
        start_phys  = {22'h0, b17, 17'h0};
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic do_save(input int p, input bit b17);
        save_valid = 1'b1;
        save_page  = 2'(p);
        save_phys  = {22'h0, b17, 17'h0};
        @(negedge clk);
        save_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_cnt != 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int lat;
        for (int i = 0; i < WORDS; i++) begin
            mem[i]    = {32'(i), 32'hC0DE0000 ^ 32'(i * 7)};
            shadow[i] = mem[i];
            orig[i]   = mem[i];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !done_dirty && !mem_req, "R1 reset state",
            {busy, done, done_dirty, mem_req}, 0);

        // R3: no recorded value -> nothing happens
        do_start(0, 1'b1);
        wait_idle();
        chk(page_vs_orig(0) == 0, "R3 unrecorded page untouched", page_vs_orig(0), 0);
        @(negedge clk);

        // R2: recorded 0, new 1 -> swap; R9 latency measured
        do_save(0, 1'b0);
        do_start(0, 1'b1);
        lat = 1;
        while (!done) begin @(negedge clk); lat++; end
        chk(lat == SWAP_CYC + 1, "R9 swap latency", lat, SWAP_CYC + 1);
        chk(mem[5] === orig[13] && mem[13] === orig[5], "R4 first chunk beat pair",
            mem[5], orig[13]);
        @(negedge clk);

        // R2: equal bits -> no swap
        do_start(0, 1'b0);
        wait_idle();
        chk(mem_vs_shadow() == 0, "R2 equal bits keep page", mem_vs_shadow(), 0);
        @(negedge clk);

        // R5: recorded value unchanged by swap -> second swap restores
        do_start(0, 1'b1);
        wait_idle();
        chk(page_vs_orig(0) == 0, "R5 double swap restores", page_vs_orig(0), 0);
        @(negedge clk);

        // R2 other polarity, R7 ignored start, R5 save while busy
        do_save(1, 1'b1);
        do_save(2, 1'b0);
        do_start(1, 1'b0);
        repeat (100) @(negedge clk);
        do_start(2, 1'b1);
        do_save(3, 1'b1);
        wait_idle();
        chk(page_vs_orig(2) == 0, "R7 start while busy ignored", page_vs_orig(2), 0);
        chk(page_vs_orig(1) != 0, "R2 opposite polarity swapped", page_vs_orig(1), 512);

        // back-to-back start in the done cycle, using the save taken while busy
        do_start(3, 1'b0);
        wait_idle();
        chk(page_vs_orig(3) != 0, "R5 save during busy used", page_vs_orig(3), 512);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule